// File: doc/BRIEF.md
# Available-Bit-Rate Source Rate Controller

This block governs the cell emission of one available-bit-rate connection at the sending end. It holds the allowed cell rate in a register and spaces outgoing cells by a gap counter. The gap is reloaded, on every cell sent, with the number of clock ticks per cell that corresponds to that rate. After a fixed number of data cells it schedules a resource-management cell. That cell carries the present rate and goes out at the next free slot, whether or not user data is waiting.

Backward resource-management cells that come back from the network are presented on a feedback strobe, together with their congestion bit and explicit-rate field. A clear congestion bit raises the rate additively by a fraction of the peak rate. A set bit cuts it multiplicatively. The result is then capped by the explicit rate and the peak rate, and floored at the minimum rate. If no feedback arrives within a timeout window, the same multiplicative cut is applied once and the window starts again.

Top module: `abr_rate_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `rm_ccr` holds `cfg_icr` limited to the range [`cfg_mcr`, `cfg_pcr`], and neither emit output is high.
- R2: A feedback strobe with `fb_ci`=0 sets the rate to old + (`cfg_pcr` >> `cfg_rif_sh`) before limiting. The new value is visible on `rm_ccr` one cycle after the strobe.
- R3: A feedback strobe with `fb_ci`=1 sets the rate to old − (old >> `cfg_rdf_sh`) before limiting.
- R4: After a feedback update the rate never exceeds the smaller of `fb_er` and `cfg_pcr`.
- R5: The rate never falls below `cfg_mcr`. The floor wins over an explicit rate below it.
- R6: When TMO_CYC cycles pass without a feedback strobe, the rate takes the decrease of R3 once, floored at `cfg_mcr`, and the window restarts. A feedback strobe restarts the window too. Without one of these two events the rate does not change.
- R7: While cells are sent back to back, successive emit pulses are TICK_NUM / rate cycles apart, integer quotient, using the rate in force at the earlier pulse.
- R8: `emit_data` rises only when `data_avail` was high at the preceding edge, and at most one emit output is high in any cycle.
- R9: After RM_PERIOD−1 data cells the next cell is a resource-management cell, sent even if no data is available. With data always available, cells number RM_PERIOD, 2·RM_PERIOD, … are resource-management cells.
- R10: `rm_ccr` always shows the present allowed rate that the pacing uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_avail | input | 1 | User data cell waiting |
| fb_valid | input | 1 | One-cycle strobe: backward RM cell returned |
| fb_ci | input | 1 | Congestion bit of returned cell |
| fb_er | input | RATE_W | Explicit rate of returned cell |
| cfg_pcr | input | RATE_W | Peak rate |
| cfg_mcr | input | RATE_W | Minimum rate |
| cfg_icr | input | RATE_W | Starting rate |
| cfg_rif_sh | input | SHIFT_W | Increase factor as right shift of peak rate |
| cfg_rdf_sh | input | SHIFT_W | Decrease factor as right shift of current rate |
| emit_data | output | 1 | Send one data cell this cycle |
| emit_rm | output | 1 | Send one RM cell this cycle |
| rm_ccr | output | RATE_W | Current rate to write into RM cells |

## Verification
The assertions assume a fixed configuration with 1 ≤ `cfg_mcr` ≤ `cfg_pcr` ≤ TICK_NUM. They also assume that `fb_valid` is a single-cycle strobe driven synchronously. The bench holds all configuration inputs constant from time zero, before reset is released. It drives every input at the falling edge, with feedback pulses exactly one cycle wide. The explicit-rate values it uses fall above, between and below the configured bounds, so each clamp is reached.

// File: rtl/abr_pkg.sv
package abr_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_RAISE = 2'd1,
    UPD_CUT_FB = 2'd2,
    UPD_CUT_TMO = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/abr_fb_timer.sv
module abr_fb_timer #(
  parameter int TMO_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_valid,
  output logic tmo_evt
);
  localparam int CNT_W = $clog2(TMO_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tmo_evt = !fb_valid && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (fb_valid || tmo_evt) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/abr_rate_unit.sv
module abr_rate_unit
  import abr_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fb_valid,
  input  logic               fb_ci,
  input  logic [RATE_W-1:0]  fb_er,
  input  logic               tmo_evt,
  input  logic [RATE_W-1:0]  cfg_pcr,
  input  logic [RATE_W-1:0]  cfg_mcr,
  input  logic [RATE_W-1:0]  cfg_icr,
  input  logic [SHIFT_W-1:0] cfg_rif_sh,
  input  logic [SHIFT_W-1:0] cfg_rdf_sh,
  output logic [RATE_W-1:0]  ccr
);
  localparam int EXT_W = RATE_W + 1;

  upd_kind_e         kind;
  logic [EXT_W-1:0]  raised, cut, cand, limit, capped, floored, init_val;

  always_comb begin
    if (fb_valid) kind = fb_ci ? UPD_CUT_FB : UPD_RAISE;
    else if (tmo_evt) kind = UPD_CUT_TMO;
    else kind = UPD_HOLD;
  end

  always_comb begin
    raised = {1'b0, ccr} + {1'b0, (cfg_pcr >> cfg_rif_sh)};
    cut = {1'b0, ccr - (ccr >> cfg_rdf_sh)};
    cand = (kind == UPD_RAISE) ? raised : cut;
    if (kind == UPD_CUT_TMO) limit = {1'b0, cfg_pcr};
    else limit = (fb_er < cfg_pcr) ? {1'b0, fb_er} : {1'b0, cfg_pcr};
    capped = (cand < limit) ? cand : limit;
    floored = (capped > {1'b0, cfg_mcr}) ? capped : {1'b0, cfg_mcr};
    init_val = (cfg_icr < cfg_pcr) ? {1'b0, cfg_icr} : {1'b0, cfg_pcr};
    if (init_val < {1'b0, cfg_mcr}) init_val = {1'b0, cfg_mcr};
  end

  always_ff @(posedge clk) begin
    if (rst) ccr <= init_val[RATE_W-1:0];
    else if (kind != UPD_HOLD) ccr <= floored[RATE_W-1:0];
  end
endmodule

// File: rtl/abr_cell_pacer.sv
module abr_cell_pacer #(
  parameter int RATE_W = 16,
  parameter int TICK_NUM = 4096,
  parameter int RM_PERIOD = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] ccr,
  input  logic              data_avail,
  output logic              emit_data,
  output logic              emit_rm
);
  localparam int GAP_W = $clog2(TICK_NUM + 1);
  localparam int CNT_W = $clog2(RM_PERIOD);
  localparam logic [CNT_W-1:0] RM_DUE = CNT_W'(RM_PERIOD - 1);

  logic [GAP_W-1:0] gap_q, reload;
  logic [CNT_W-1:0] dcnt_q;
  logic [31:0]      quo;
  logic             rm_due;

  always_comb begin
    quo = 32'(TICK_NUM) / ((ccr == '0) ? 32'd1 : 32'(ccr));
    reload = (quo == 32'd0) ? '0 : GAP_W'(quo - 32'd1);
  end

  assign rm_due = (dcnt_q == RM_DUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
      dcnt_q <= '0;
      emit_data <= 1'b0;
      emit_rm <= 1'b0;
    end else begin
      emit_data <= 1'b0;
      emit_rm <= 1'b0;
      if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end else if (rm_due) begin
        emit_rm <= 1'b1;
        dcnt_q <= '0;
        gap_q <= reload;
      end else if (data_avail) begin
        emit_data <= 1'b1;
        dcnt_q <= dcnt_q + 1'b1;
        gap_q <= reload;
      end
    end
  end
endmodule

// File: rtl/abr_rate_ctrl.sv
module abr_rate_ctrl #(
  parameter int RATE_W = 16,
  parameter int SHIFT_W = 4,
  parameter int TICK_NUM = 4096,
  parameter int TMO_CYC = 2000,
  parameter int RM_PERIOD = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               data_avail,
  input  logic               fb_valid,
  input  logic               fb_ci,
  input  logic [RATE_W-1:0]  fb_er,
  input  logic [RATE_W-1:0]  cfg_pcr,
  input  logic [RATE_W-1:0]  cfg_mcr,
  input  logic [RATE_W-1:0]  cfg_icr,
  input  logic [SHIFT_W-1:0] cfg_rif_sh,
  input  logic [SHIFT_W-1:0] cfg_rdf_sh,
  output logic               emit_data,
  output logic               emit_rm,
  output logic [RATE_W-1:0]  rm_ccr
);
  logic tmo_evt;

  abr_fb_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst), .fb_valid(fb_valid), .tmo_evt(tmo_evt)
  );

  abr_rate_unit #(.RATE_W(RATE_W), .SHIFT_W(SHIFT_W)) u_rate (
    .clk(clk), .rst(rst), .fb_valid(fb_valid), .fb_ci(fb_ci), .fb_er(fb_er),
    .tmo_evt(tmo_evt), .cfg_pcr(cfg_pcr), .cfg_mcr(cfg_mcr), .cfg_icr(cfg_icr),
    .cfg_rif_sh(cfg_rif_sh), .cfg_rdf_sh(cfg_rdf_sh), .ccr(rm_ccr)
  );

  abr_cell_pacer #(.RATE_W(RATE_W), .TICK_NUM(TICK_NUM), .RM_PERIOD(RM_PERIOD)) u_pacer (
    .clk(clk), .rst(rst), .ccr(rm_ccr), .data_avail(data_avail),
    .emit_data(emit_data), .emit_rm(emit_rm)
  );
endmodule

// File: rtl/abr_rate_ctrl_chk.sv
module abr_rate_ctrl_chk #(
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              data_avail,
  input logic              fb_valid,
  input logic              tmo_evt,
  input logic [RATE_W-1:0] cfg_pcr,
  input logic [RATE_W-1:0] cfg_mcr,
  input logic              emit_data,
  input logic              emit_rm,
  input logic [RATE_W-1:0] rm_ccr
);
  AST_ONE_EMIT: assert property (@(posedge clk) disable iff (rst)
    !(emit_data && emit_rm)); // R8

  AST_DATA_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (rst)
    $rose(emit_data) |-> $past(data_avail)); // R8

  AST_RATE_FLOOR: assert property (@(posedge clk) disable iff (rst)
    rm_ccr >= cfg_mcr); // R5

  AST_RATE_CEIL: assert property (@(posedge clk) disable iff (rst)
    rm_ccr <= cfg_pcr); // R4

  AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!fb_valid && !tmo_evt) |=> $stable(rm_ccr)); // R6
endmodule

bind abr_rate_ctrl abr_rate_ctrl_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .data_avail(data_avail), .fb_valid(fb_valid),
  .tmo_evt(tmo_evt), .cfg_pcr(cfg_pcr), .cfg_mcr(cfg_mcr),
  .emit_data(emit_data), .emit_rm(emit_rm), .rm_ccr(rm_ccr)
);

// File: tb/tb_abr_rate_ctrl.sv
module tb_abr_rate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RATE_W = 16;
  localparam int SHIFT_W = 4;
  localparam int TICK_NUM = 4096;
  localparam int TMO_CYC = 2000;
  localparam int RM_PERIOD = 32;
  localparam int PCR = 1024, MCR = 64, ICR = 256, RIF = 4, RDF = 4;
  localparam int WD_CYC = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_avail = 1'b0;
  logic fb_valid = 1'b0;
  logic fb_ci = 1'b0;
  logic [RATE_W-1:0] fb_er = '0;
  logic emit_data, emit_rm;
  logic [RATE_W-1:0] rm_ccr;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  abr_rate_ctrl #(.RATE_W(RATE_W), .SHIFT_W(SHIFT_W), .TICK_NUM(TICK_NUM),
                  .TMO_CYC(TMO_CYC), .RM_PERIOD(RM_PERIOD)) dut (
    .clk(clk), .rst(rst), .data_avail(data_avail), .fb_valid(fb_valid),
    .fb_ci(fb_ci), .fb_er(fb_er), .cfg_pcr(RATE_W'(PCR)), .cfg_mcr(RATE_W'(MCR)),
    .cfg_icr(RATE_W'(ICR)), .cfg_rif_sh(SHIFT_W'(RIF)), .cfg_rdf_sh(SHIFT_W'(RDF)),
    .emit_data(emit_data), .emit_rm(emit_rm), .rm_ccr(rm_ccr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lim(input int v, input int hi);
    int r;
    r = (v < hi) ? v : hi;
    return (r > MCR) ? r : MCR;
  endfunction

  // behavioural reference model
  int m_ccr, m_gap, m_cnt, m_tmo;
  bit m_ed, m_er;

  always @(posedge clk) begin
    int old;
    bit tmo;
    if (rst) begin
      m_ccr = lim(ICR, PCR); m_gap = 0; m_cnt = 0; m_tmo = 0; m_ed = 0; m_er = 0;
    end else begin
      old = m_ccr;
      tmo = !fb_valid && (m_tmo == TMO_CYC - 1);
      m_tmo = (fb_valid || tmo) ? 0 : m_tmo + 1;
      m_ed = 0; m_er = 0;
      if (m_gap != 0) m_gap--;
      else if (m_cnt == RM_PERIOD - 1) begin
        m_er = 1; m_cnt = 0; m_gap = TICK_NUM / old - 1;
      end else if (data_avail) begin
        m_ed = 1; m_cnt++; m_gap = TICK_NUM / old - 1;
      end
      if (fb_valid) begin
        int c;
        c = fb_ci ? old - (old >> RDF) : old + (PCR >> RIF);
        m_ccr = lim(c, (int'(fb_er) < PCR) ? int'(fb_er) : PCR);
      end else if (tmo) m_ccr = lim(old - (old >> RDF), PCR);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(emit_data === m_ed && emit_rm === m_er, "R7 emit pattern",
            {emit_data, emit_rm}, {m_ed, m_er});
      check(int'(rm_ccr) == m_ccr, "R10 rate", rm_ccr, m_ccr);
    end
  end

  task automatic feedback(input bit ci, input int er, input int exp, input string req);
    @(negedge clk);
    fb_valid = 1'b1; fb_ci = ci; fb_er = RATE_W'(er);
    @(negedge clk);
    fb_valid = 1'b0;
    check(int'(rm_ccr) == exp, req, rm_ccr, exp);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nd, nr, cells, rate, gap;
    bit order_ok;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(int'(rm_ccr) == ICR, "R1 reset rate", rm_ccr, ICR);
    check(!emit_data && !emit_rm, "R1 reset emits", {emit_data, emit_rm}, 0);
    data_avail = 1'b1;
    rst = 1'b0;
    @(negedge clk);
    check(int'(rm_ccr) == ICR, "R1 rate after reset", rm_ccr, ICR);

    // R9: RM cell ratio with data always waiting
    nd = 0; nr = 0; cells = 0; order_ok = 1;
    while (cells < 2 * RM_PERIOD) begin
      if (emit_data || emit_rm) begin
        cells++;
        if (emit_rm) nr++; else nd++;
        if (emit_rm != (cells % RM_PERIOD == 0)) order_ok = 0;
      end
      @(negedge clk);
    end
    check(nr == 2, "R9 rm count", nr, 2);
    check(nd == 2 * RM_PERIOD - 2, "R9 data count", nd, 2 * RM_PERIOD - 2);
    check(order_ok, "R9 rm position", order_ok, 1);

    // R2: additive increase
    feedback(1'b0, 65535, ICR + (PCR >> RIF), "R2 increase");
    // R4: peak-rate cap
    rate = ICR + (PCR >> RIF);
    for (int i = 0; i < 14; i++) begin
      rate = lim(rate + (PCR >> RIF), PCR);
      feedback(1'b0, 65535, rate, "R2 increase step");
    end
    check(int'(rm_ccr) == PCR, "R4 capped at peak", rm_ccr, PCR);
    // R4: explicit-rate cap
    feedback(1'b0, 500, 500, "R4 explicit cap");
    // R3: multiplicative decrease
    feedback(1'b1, 65535, 500 - (500 >> RDF), "R3 decrease");
    // R5: floor beats explicit rate
    feedback(1'b0, 10, MCR, "R5 floor over explicit");
    feedback(1'b1, 65535, MCR, "R5 floor on decrease");

    // back to peak
    rate = MCR;
    for (int i = 0; i < 16; i++) begin
      rate = lim(rate + (PCR >> RIF), PCR);
      feedback(1'b0, 65535, rate, "R2 climb");
    end

    // R7: spacing at peak rate
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      @(negedge clk);
      while (!(emit_data || emit_rm)) begin gap++; @(negedge clk); end
    end
    gap = 1;
    @(negedge clk);
    while (!(emit_data || emit_rm)) begin gap++; @(negedge clk); end
    check(gap == TICK_NUM / PCR, "R7 spacing", gap, TICK_NUM / PCR);

    // R6: timeout decrease
    feedback(1'b0, 65535, PCR, "R6 setup");
    repeat (TMO_CYC - 1) @(negedge clk);
    check(int'(rm_ccr) == PCR, "R6 held before timeout", rm_ccr, PCR);
    @(negedge clk);
    check(int'(rm_ccr) == PCR - (PCR >> RDF), "R6 timeout cut", rm_ccr, PCR - (PCR >> RDF));
    repeat (TMO_CYC - 1) @(negedge clk);
    rate = PCR - (PCR >> RDF);
    check(int'(rm_ccr) == rate, "R6 window restarted", rm_ccr, rate);
    @(negedge clk);
    check(int'(rm_ccr) == rate - (rate >> RDF), "R6 second cut", rm_ccr, rate - (rate >> RDF));

    // R8: no data cells without data
    data_avail = 1'b0;
    @(negedge clk);
    nd = 0; nr = 0;
    repeat (400) begin
      @(negedge clk);
      if (emit_data) nd++;
      if (emit_rm) nr++;
    end
    check(nd == 0, "R8 no data when idle", nd, 0);
    check(nr <= 1, "R9 at most one pending rm", nr, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule